// File: doc/BRIEF.md
# Bidirectional Serial Bit Timer

This block times a serial stream one bit at a time. In transmit mode a processor writes a single data bit into a one-bit holding buffer. The timer moves that bit onto the transmit pin and holds it there for one bit period, measured by a down-counter loaded from the `reload` input. When the timer takes a bit, it raises a "buffer empty" flag so the processor can supply the next bit. If no new bit is waiting when the period runs out, the pin keeps its last level, the timer stops and a "done" flag is raised.

In receive mode the same registers measure the input instead. A synchronised copy of the receive pin is watched for level changes. Each change latches the elapsed cycle count from a free-running counter, records whether the edge was rising or falling, and raises an edge flag. If the counter runs past its maximum value before the next edge, an overflow flag is raised and the counter wraps. Both flags clear when the status register is read, and a maskable interrupt is the OR of the enabled flags.

Top module: `serial_bit_timer`

## Requirements
- R1: After reset, all three registers read 0, and `tx_pin` and `irq` are 0.
- R2: Each read returns its data on `rdata` one cycle after `rd_en`. Address 0 is the control register, which reads back what was written: bits [1:0] mode, bit 2 enables the interrupt for flag A, bit 3 enables the interrupt for flag B.
- R3: In modes 01 and 11, a write to address 1 loads bit 1 of `wdata` into the transmit buffer. An idle timer drives the buffered bit onto `tx_pin` on the next clock. Each bit then stays on the pin for reload+1 cycles, and a bit already waiting follows with no gap.
- R4: In transmit modes, flag A (status bit 0) is set on the clock at which the timer takes a bit from the buffer.
- R5: In transmit modes, when a bit period ends and the buffer is empty, `tx_pin` keeps its level, the timer stops, and flag B (status bit 2) is set.
- R6: In mode 10, every level change on `rx_pin` sets flag B. Status bit 1 then reads 1 after a rising edge and 0 after a falling edge.
- R7: In mode 10, address 2 returns the number of clock cycles between the last two level changes of `rx_pin`, modulo 2^CW. The edge cycle itself counts as zero, and the counter restarts after each capture.
- R8: In mode 10, flag A is set when the interval counter passes its maximum value without an edge, and the counter then wraps to 0.
- R9: A read of address 1 returns the flags and then clears both of them. A flag that is set on the same clock as the read stays set.
- R10: `irq` is 1 exactly when (flag A and enable bit 2) or (flag B and enable bit 3) holds, and it changes on the same clock as the flags.
- R11: In mode 00, writes to the buffer do not move `tx_pin`, and `rx_pin` changes raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address (0 control, 1 status/data, 2 count) |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| reload | input | CW | Bit period minus one, in transmit modes |
| rx_pin | input | 1 | Serial input, measured in receive mode |
| tx_pin | output | 1 | Serial output, driven in transmit modes |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the following about the inputs:
- `rd_en` and `wr_en` are never high on the same cycle.
- `addr` stays within the three defined registers.
- `reload` does not change while a transmit run is in progress.

The stimulus respects all three. Every bus access happens on its own cycle, `reload` changes only between runs, and `rx_pin` moves only at falling clock edges. The receive sweep reads the status register soon after each edge. This keeps the gaps between intervals well short of overflow, so flag A is raised only by the interval under test.

// File: rtl/sbt_pkg.sv
`timescale 1ns/1ps
package sbt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_TX  = 2'b01,
    MODE_RX  = 2'b10,
    MODE_TXB = 2'b11
  } sbt_mode_e;

  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;

  // status field positions
  localparam int B_FA  = 0;
  localparam int B_DAT = 1;
  localparam int B_FB  = 2;

  // control field positions
  localparam int B_MODE = 0;
  localparam int B_IEA  = 2;
  localparam int B_IEB  = 3;
endpackage

// File: rtl/sbt_tx_engine.sv
`timescale 1ns/1ps
module sbt_tx_engine #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          buf_full,
  input  logic          buf_bit,
  input  logic [CW-1:0] reload,
  output logic          take_o,
  output logic          done_o,
  output logic          pin_o,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o
);
  logic          busy_q;
  logic          pin_q;
  logic [CW-1:0] cnt_q;
  logic          expired;

  assign expired = busy_q && (cnt_q == '0);

  always_comb begin
    take_o = en && buf_full && (!busy_q || expired);
    done_o = en && expired && !buf_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pin_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
    end else if (take_o) begin
      pin_q  <= buf_bit;
      cnt_q  <= reload;
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pin_o  = pin_q;
  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sbt_rx_engine.sv
`timescale 1ns/1ps
module sbt_rx_engine #(
  parameter int CW   = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pin,
  output logic          edge_o,
  output logic          level_o,
  output logic          ovf_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [CW-1:0]   cnt_q;

  generate
    if (SYNC == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC-2:0], pin};
      end
    end
  endgenerate

  assign level_o = sync_q[SYNC-1];
  assign edge_o  = en && (level_o != prev_q);
  assign ovf_o   = en && !edge_o && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= level_o;
      if (!en)         cnt_q <= '0;
      else if (edge_o) cnt_q <= CW'(1);
      else             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/serial_bit_timer.sv
`timescale 1ns/1ps
module serial_bit_timer
  import sbt_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 10,
  parameter int AW   = 2,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [CW-1:0] reload,
  input  logic          rx_pin,
  output logic          tx_pin,
  output logic          irq
);
  sbt_mode_e     mode_q, mode_d;
  logic          iea_q, iea_d, ieb_q, ieb_d;
  logic          flag_a_q, flag_a_d, flag_b_q, flag_b_d;
  logic          buf_full_q, buf_bit_q;
  logic          rx_pol_q;
  logic [CW-1:0] cap_q;
  logic [DW-1:0] rdata_q, rd_word;
  logic          irq_q;

  logic          tx_en, rx_en;
  logic          wr_ctrl, wr_stat, rd_stat;
  logic          tx_take, tx_done, tx_busy;
  logic [CW-1:0] tx_cnt;
  logic          rx_edge, rx_level, rx_ovf;
  logic [CW-1:0] rx_cnt;
  logic          set_a, set_b;
  logic          unused_wdata;

  assign unused_wdata = ^wdata;

  assign tx_en   = mode_q[0];
  assign rx_en   = (mode_q == MODE_RX);
  assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
  assign wr_stat = wr_en && (addr == AW'(A_STAT));
  assign rd_stat = rd_en && (addr == AW'(A_STAT));

  sbt_tx_engine #(.CW(CW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .en       (tx_en),
    .buf_full (buf_full_q),
    .buf_bit  (buf_bit_q),
    .reload   (reload),
    .take_o   (tx_take),
    .done_o   (tx_done),
    .pin_o    (tx_pin),
    .busy_o   (tx_busy),
    .cnt_o    (tx_cnt)
  );

  sbt_rx_engine #(.CW(CW), .SYNC(SYNC)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .en      (rx_en),
    .pin     (rx_pin),
    .edge_o  (rx_edge),
    .level_o (rx_level),
    .ovf_o   (rx_ovf),
    .cnt_o   (rx_cnt)
  );

  assign set_a = tx_take || rx_ovf;
  assign set_b = tx_done || rx_edge;

  // next state of control and flags; a new event beats the read clear
  always_comb begin
    mode_d   = wr_ctrl ? sbt_mode_e'(wdata[B_MODE +: 2]) : mode_q;
    iea_d    = wr_ctrl ? wdata[B_IEA] : iea_q;
    ieb_d    = wr_ctrl ? wdata[B_IEB] : ieb_q;
    flag_a_d = set_a || (flag_a_q && !rd_stat);
    flag_b_d = set_b || (flag_b_q && !rd_stat);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_OFF;
      iea_q    <= 1'b0;
      ieb_q    <= 1'b0;
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      iea_q    <= iea_d;
      ieb_q    <= ieb_d;
      flag_a_q <= flag_a_d;
      flag_b_q <= flag_b_d;
      irq_q    <= (flag_a_d && iea_d) || (flag_b_d && ieb_d);
    end
  end

  // one-bit transmit buffer: a write in the same cycle as a take refills it
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full_q <= 1'b0;
      buf_bit_q  <= 1'b0;
    end else if (wr_stat && tx_en) begin
      buf_full_q <= 1'b1;
      buf_bit_q  <= wdata[B_DAT];
    end else if (tx_take) begin
      buf_full_q <= 1'b0;
    end
  end

  // receive capture
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q    <= '0;
      rx_pol_q <= 1'b0;
    end else if (rx_edge) begin
      cap_q    <= rx_cnt;
      rx_pol_q <= rx_level;
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      AW'(A_CTRL): begin
        rd_word[B_MODE +: 2] = mode_q;
        rd_word[B_IEA]       = iea_q;
        rd_word[B_IEB]       = ieb_q;
      end
      AW'(A_STAT): begin
        rd_word[B_FA]  = flag_a_q;
        rd_word[B_DAT] = rx_en ? rx_pol_q : buf_bit_q;
        rd_word[B_FB]  = flag_b_q;
      end
      AW'(A_CNT): rd_word[CW-1:0] = cap_q;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/sbt_checker.sv
`timescale 1ns/1ps
module sbt_checker #(
  parameter int CW = 10,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic          tx_pin,
  input logic          irq,
  input logic [1:0]    mode_q,
  input logic          iea_q,
  input logic          ieb_q,
  input logic          flag_a_q,
  input logic          flag_b_q,
  input logic          set_a,
  input logic          tx_busy,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_edge,
  input logic [CW-1:0] rx_cnt,
  input logic          buf_full_q
);
  assert_pin_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && tx_cnt != '0) |=> $stable(tx_pin));

  assert_buffer_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(1) && mode_q[0]) |=> buf_full_q);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_a |=> flag_a_q);

  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(1) && !set_a) |=> !flag_a_q);

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (rst)
    irq == ((flag_a_q && iea_q) || (flag_b_q && ieb_q)));

  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00) |=> !$rose(flag_b_q));

  assert_rx_restart_R7: assert property (@(posedge clk) disable iff (rst)
    rx_edge |=> (rx_cnt == CW'(1)));
endmodule

bind serial_bit_timer sbt_checker #(.CW(CW), .AW(AW)) u_sbt_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .tx_pin     (tx_pin),
  .irq        (irq),
  .mode_q     (mode_q),
  .iea_q      (iea_q),
  .ieb_q      (ieb_q),
  .flag_a_q   (flag_a_q),
  .flag_b_q   (flag_b_q),
  .set_a      (set_a),
  .tx_busy    (tx_busy),
  .tx_cnt     (tx_cnt),
  .rx_edge    (rx_edge),
  .rx_cnt     (rx_cnt),
  .buf_full_q (buf_full_q)
);

// File: tb/serial_bit_timer_bench.sv
`timescale 1ns/1ps
module serial_bit_timer_bench;
  localparam int DW   = 16;
  localparam int CW   = 4;
  localparam int AW   = 2;
  localparam int SYNC = 2;
  localparam int CMAX = 1 << CW;
  localparam int NB   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [CW-1:0] reload = '0;
  logic          rx_pin = 1'b0;
  logic          tx_pin;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  serial_bit_timer #(.DW(DW), .CW(CW), .AW(AW), .SYNC(SYNC)) u_serial_bit_timer (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .reload (reload),
    .rx_pin (rx_pin),
    .tx_pin (tx_pin),
    .irq    (irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling clock edge
  task automatic bus_wr(input int a, input int d);
    addr = AW'(a); wdata = DW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, output int d);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int v;
    rst = 1'b1;
    idle(4);
    rst = 1'b0;

    // R1 reset state
    check("R1", "tx_pin", int'(tx_pin), 0);
    check("R1", "irq", int'(irq), 0);
    bus_rd(0, v); check("R1", "ctrl", v, 0);
    bus_rd(1, v); check("R1", "status", v, 0);
    bus_rd(2, v); check("R1", "count", v, 0);

    // R2 control readback
    bus_wr(0, 'hD); bus_rd(0, v); check("R2", "ctrl readback D", v, 'hD);
    bus_wr(0, 'h6); bus_rd(0, v); check("R2", "ctrl readback 6", v, 'h6);
    bus_wr(0, 0);

    // transmit sweep over bit periods; R=3 runs in mode 11
    for (int r = 0; r < 6; r++) begin
      int mode, ie, pat, last;
      mode = (r == 3) ? 3 : 1;
      ie   = (r % 2 == 0) ? 8 : 4;
      pat  = (r * 7 + 5) & 15;
      last = (pat >> (NB - 1)) & 1;
      reload = CW'(r);
      bus_wr(0, ie | mode);
      bus_rd(1, v);
      bus_wr(1, (pat & 1) << 1);
      for (int c = 1; c <= 1 + NB * (r + 1) + 2; c++) begin
        int k, exp_pin, exp_irq;
        if (((c - 1) % (r + 1) == 0) && ((c - 1) / (r + 1) + 1 < NB)) begin
          addr = AW'(1);
          wdata = DW'(((pat >> ((c - 1) / (r + 1) + 1)) & 1) << 1);
          wr_en = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        k = (c - 1) / (r + 1);
        exp_pin = (k < NB) ? ((pat >> k) & 1) : last;
        check("R3", $sformatf("pin r=%0d c=%0d", r, c), int'(tx_pin), exp_pin);
        if (ie == 4) exp_irq = 1;                       // R4 flag A on first take
        else exp_irq = (c >= 1 + NB * (r + 1)) ? 1 : 0; // R5 done flag
        check("R10", $sformatf("irq r=%0d c=%0d", r, c), int'(irq), exp_irq);
      end
      bus_rd(1, v);
      check("R5", $sformatf("status after run r=%0d", r), v, 5 | (last << 1));
      bus_rd(1, v);
      check("R9", $sformatf("status cleared r=%0d", r), v, last << 1);
      check("R10", "irq after clear", int'(irq), 0);
    end

    // R11 disabled mode
    begin
      int hold;
      bus_wr(0, 0);
      hold = int'(tx_pin);
      bus_wr(1, (1 - hold) << 1);
      idle(6);
      check("R11", "pin held in mode 00", int'(tx_pin), hold);
      rx_pin = ~rx_pin;
      idle(5);
      bus_rd(1, v);
      check("R11", "no flags in mode 00", v & 5, 0);
    end

    // receive sweep over intervals, crossing the counter limit
    bus_wr(0, 2);
    rx_pin = ~rx_pin;
    idle(4);
    bus_rd(1, v);
    for (int d = 1; d <= 20; d++) begin
      int expv;
      if (d % 2 == 1) begin
        rx_pin = ~rx_pin;
        idle(4);
        bus_rd(1, v);
        check("R6", $sformatf("edge flag pre d=%0d", d), v & 5, 4);
        check("R6", $sformatf("polarity pre d=%0d", d), (v >> 1) & 1, int'(rx_pin));
      end
      rx_pin = ~rx_pin;
      idle(d);
      rx_pin = ~rx_pin;
      idle(4);
      bus_rd(1, v);
      expv = 4 | (int'(rx_pin) << 1) | ((d >= CMAX) ? 1 : 0);
      check("R6", $sformatf("status d=%0d", d), v, expv);
      check("R8", $sformatf("overflow d=%0d", d), v & 1, (d >= CMAX) ? 1 : 0);
      bus_rd(2, v);
      check("R7", $sformatf("interval d=%0d", d), v, d % CMAX);
    end

    summary();
  end
endmodule